// File: doc/BRIEF.md
# PC Card Byte-Lane Steering

This block sits between the host side of a 16-bit PC Card memory socket and an internal word-wide memory array. The array is built from paired devices: one holds the even byte and one holds the odd byte. The block decodes the two active-low card enables, address bit zero, the read and write strobes and the attribute-plane select. From these it chooses the access mode, then routes each host byte lane to or from the correct half of the array word.

Toward the host, the block returns read data with a separate drive enable for each lane, so the pad ring can tri-state each byte on its own. Toward the array, it issues a word address and a plane select. It also issues a read indication, a two-bit byte-write mask and write data in which a byte arriving on one host lane is copied into both array lanes. The block is purely combinational. Any timing of the strobes belongs to the surrounding logic.

Top module: `pccard_lane_steer`

## Requirements
- R1: With both card enables high, neither host lane is driven and the write mask is 00, whatever the other inputs are.
- R2: Enable 1 low with enable 2 high and address bit 0 low is an even-byte access on the low lane. A read drives only lane 0 (host_doe = 01) with array bits 7:0. A write sets the mask to 01.
- R3: Enable 1 low with enable 2 high and address bit 0 high reaches the odd byte through the low lane. A common-plane read drives only lane 0 with array bits 15:8. A write sets the mask to 10.
- R4: Both enables low is a word access. A common-plane read drives both lanes (host_doe = 11) with the array word unchanged. A write sets the mask to 11 and passes host_din through unchanged.
- R5: Enable 1 high with enable 2 low is an odd-only access on the high lane. A read drives only lane 1 (host_doe = 10) with array bits 15:8. A write sets the mask to 10 and takes the byte from host bits 15:8.
- R6: A read needs the output strobe low and the write strobe high. With both strobes high, an enabled access drives no lane, writes nothing and holds arr_rd low.
- R7: With both strobes low, the cycle is a write and no host lane is driven.
- R8: With the attribute select low, an odd byte is never returned: lane 1 is not driven, and an odd access through the low lane leaves lane 0 undriven.
- R9: With the attribute select low, writes to odd bytes are dropped: mask bit 1 stays 0, so word writes keep only the even byte.
- R10: The array word address equals host address bits above bit 0. Address bit 0 has no effect on word and odd-only accesses.
- R11: In a byte-wide write, the array write data carries the selected host byte in both halves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| host_addr | input | ADDR_W | Host byte address; bit 0 picks the byte in byte-wide mode |
| host_ce1_n | input | 1 | Card enable for the even side, active low |
| host_ce2_n | input | 1 | Card enable for the odd side, active low |
| host_oe_n | input | 1 | Read strobe, active low |
| host_we_n | input | 1 | Write strobe, active low |
| host_reg_n | input | 1 | Attribute-plane select, active low |
| host_din | input | 2*LANE_W | Data arriving from the host lanes |
| host_dout | output | 2*LANE_W | Data returned to the host lanes (0 where undriven) |
| host_doe | output | 2 | Per-lane drive enable, bit 0 for the low lane |
| arr_addr | output | ADDR_W-1 | Array word address |
| arr_attr | output | 1 | Selects the attribute plane of the array |
| arr_rd | output | 1 | Array read in progress |
| arr_wr_be | output | 2 | Byte-write mask, bit 0 for the even byte |
| arr_wdata | output | 2*LANE_W | Write data toward the array |
| arr_rdata | input | 2*LANE_W | Word read from the array |

## Verification
The bench drives all four enable combinations, with both strobe polarities and both planes. It puts unlike values on the two host lanes, so that reading from the wrong lane, returning the wrong byte, or failing to copy the byte into both array lanes each give a different value. Word reads after byte-wide and odd-only writes show whether the mask touched only the intended byte. Word accesses are repeated with address bit 0 toggled to show that bit has no effect. In the attribute plane, odd accesses check the port mask and the drive enables directly, and a later even read shows that the stored even byte stayed intact.

// File: rtl/lane_pkg.sv
package lane_pkg;

   typedef enum logic [2:0] {
      MODE_IDLE      = 3'd0,
      MODE_BYTE_EVEN = 3'd1,
      MODE_BYTE_ODD  = 3'd2,
      MODE_WORD      = 3'd3,
      MODE_ODD_ONLY  = 3'd4
   } lane_mode_e;

   typedef struct packed {
      lane_mode_e mode;
      logic       rd_en;
      logic       wr_en;
      logic       attr;
   } lane_ctl_t;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
   import lane_pkg::*;
(
   input  logic      ce1_n,
   input  logic      ce2_n,
   input  logic      a0,
   input  logic      oe_n,
   input  logic      we_n,
   input  logic      reg_n,
   output lane_ctl_t ctl
);

   lane_mode_e mode;
   logic       active;

   always_comb begin
      unique case ({ce2_n, ce1_n})
         2'b11:   mode = MODE_IDLE;
         2'b10:   mode = a0 ? MODE_BYTE_ODD : MODE_BYTE_EVEN;
         2'b00:   mode = MODE_WORD;
         default: mode = MODE_ODD_ONLY;
      endcase
   end

   assign active    = (mode != MODE_IDLE);
   assign ctl.mode  = mode;
   // a low write strobe wins over a low read strobe
   assign ctl.wr_en = active & ~we_n;
   assign ctl.rd_en = active & ~oe_n & we_n;
   assign ctl.attr  = ~reg_n;

endmodule

// File: rtl/lane_rd_mux.sv
module lane_rd_mux
   import lane_pkg::*;
#(
   parameter int LANE_W        = 8,
   parameter bit ATTR_ODD_MASK = 1'b1,
   localparam int DATA_W       = 2 * LANE_W
)(
   input  lane_ctl_t         ctl,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] host_dout,
   output logic [1:0]        host_doe
);

   logic odd_ok;

   generate
      if (ATTR_ODD_MASK) begin : g_mask
         assign odd_ok = ~ctl.attr;
      end else begin : g_nomask
         assign odd_ok = 1'b1;
      end
   endgenerate

   logic [LANE_W-1:0] even_b, odd_b;
   assign even_b = arr_rdata[LANE_W-1:0];
   assign odd_b  = arr_rdata[DATA_W-1:LANE_W];

   always_comb begin
      host_doe  = 2'b00;
      host_dout = '0;
      if (ctl.rd_en) begin
         unique case (ctl.mode)
            MODE_BYTE_EVEN: begin
               host_doe[0]              = 1'b1;
               host_dout[LANE_W-1:0]    = even_b;
            end
            MODE_BYTE_ODD: begin
               host_doe[0]              = odd_ok;
               host_dout[LANE_W-1:0]    = odd_ok ? odd_b : '0;
            end
            MODE_WORD: begin
               host_doe[0]              = 1'b1;
               host_dout[LANE_W-1:0]    = even_b;
               host_doe[1]              = odd_ok;
               host_dout[DATA_W-1:LANE_W] = odd_ok ? odd_b : '0;
            end
            MODE_ODD_ONLY: begin
               host_doe[1]              = odd_ok;
               host_dout[DATA_W-1:LANE_W] = odd_ok ? odd_b : '0;
            end
            default: ;
         endcase
      end
   end

   // R8
   always_comb begin
      if (ATTR_ODD_MASK && ctl.attr && ctl.mode == MODE_BYTE_ODD)
         attr_low_odd_chk: assert (host_doe == 2'b00)
            else $error("attribute odd byte returned on low lane");
   end

endmodule

// File: rtl/lane_wr_steer.sv
module lane_wr_steer
   import lane_pkg::*;
#(
   parameter int LANE_W        = 8,
   parameter bit ATTR_ODD_MASK = 1'b1,
   localparam int DATA_W       = 2 * LANE_W
)(
   input  lane_ctl_t         ctl,
   input  logic [DATA_W-1:0] host_din,
   output logic [DATA_W-1:0] arr_wdata,
   output logic [1:0]        arr_wr_be
);

   logic odd_ok;

   generate
      if (ATTR_ODD_MASK) begin : g_mask
         assign odd_ok = ~ctl.attr;
      end else begin : g_nomask
         assign odd_ok = 1'b1;
      end
   endgenerate

   logic [LANE_W-1:0] lo_b, hi_b;
   assign lo_b = host_din[LANE_W-1:0];
   assign hi_b = host_din[DATA_W-1:LANE_W];

   always_comb begin
      arr_wr_be = 2'b00;
      arr_wdata = {lo_b, lo_b};
      if (ctl.wr_en) begin
         unique case (ctl.mode)
            MODE_BYTE_EVEN: arr_wr_be = 2'b01;
            MODE_BYTE_ODD:  arr_wr_be = {odd_ok, 1'b0};
            MODE_WORD: begin
               arr_wr_be = {odd_ok, 1'b1};
               arr_wdata = host_din;
            end
            MODE_ODD_ONLY: begin
               arr_wr_be = {odd_ok, 1'b0};
               arr_wdata = {hi_b, hi_b};
            end
            default: ;
         endcase
      end
   end

   // R11
   always_comb begin
      if (arr_wr_be == 2'b10)
         odd_dup_chk: assert (arr_wdata[LANE_W-1:0] == arr_wdata[DATA_W-1:LANE_W])
            else $error("odd byte write not duplicated");
   end

endmodule

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
   import lane_pkg::*;
#(
   parameter int ADDR_W        = 26,
   parameter int LANE_W        = 8,
   parameter bit ATTR_ODD_MASK = 1'b1,
   localparam int DATA_W       = 2 * LANE_W,
   localparam int WADDR_W      = ADDR_W - 1
)(
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic               host_ce1_n,
   input  logic               host_ce2_n,
   input  logic               host_oe_n,
   input  logic               host_we_n,
   input  logic               host_reg_n,
   input  logic [DATA_W-1:0]  host_din,
   output logic [DATA_W-1:0]  host_dout,
   output logic [1:0]         host_doe,
   output logic [WADDR_W-1:0] arr_addr,
   output logic               arr_attr,
   output logic               arr_rd,
   output logic [1:0]         arr_wr_be,
   output logic [DATA_W-1:0]  arr_wdata,
   input  logic [DATA_W-1:0]  arr_rdata
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (LANE_W < 1) begin : g_bad_lane
         $error("LANE_W must be at least 1");
      end
   endgenerate

   lane_ctl_t ctl;

   lane_decode u_dec (
      .ce1_n (host_ce1_n),
      .ce2_n (host_ce2_n),
      .a0    (host_addr[0]),
      .oe_n  (host_oe_n),
      .we_n  (host_we_n),
      .reg_n (host_reg_n),
      .ctl   (ctl)
   );

   lane_rd_mux #(.LANE_W(LANE_W), .ATTR_ODD_MASK(ATTR_ODD_MASK)) u_rd (
      .ctl       (ctl),
      .arr_rdata (arr_rdata),
      .host_dout (host_dout),
      .host_doe  (host_doe)
   );

   lane_wr_steer #(.LANE_W(LANE_W), .ATTR_ODD_MASK(ATTR_ODD_MASK)) u_wr (
      .ctl       (ctl),
      .host_din  (host_din),
      .arr_wdata (arr_wdata),
      .arr_wr_be (arr_wr_be)
   );

   assign arr_addr = host_addr[ADDR_W-1:1];
   assign arr_attr = ctl.attr;
   assign arr_rd   = ctl.rd_en;

   // R1
   always_comb begin
      if (host_ce1_n && host_ce2_n)
         standby_quiet_chk: assert (host_doe == 2'b00 && arr_wr_be == 2'b00)
            else $error("activity in standby");
   end

   // R7
   always_comb begin
      if (!host_we_n)
         no_contention_chk: assert (host_doe == 2'b00)
            else $error("host lanes driven during write");
   end

   // R9
   always_comb begin
      if (ATTR_ODD_MASK && !host_reg_n)
         attr_odd_wr_chk: assert (!arr_wr_be[1])
            else $error("odd attribute byte written");
   end

   // R5
   always_comb begin
      if (host_ce1_n && !host_ce2_n)
         odd_only_lane_chk: assert (!host_doe[0] && !arr_wr_be[0])
            else $error("low lane used in odd-only access");
   end

endmodule

// File: tb/pccard_lane_steer_test.sv
module pccard_lane_steer_test;

   localparam int AW = 8;
   localparam int WN = 1 << (AW - 1);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [AW-1:0] addr = '0;
   logic ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, reg_n = 1'b1;
   logic [15:0] din = '0;
   logic [15:0] dout, wdata, rdata;
   logic [1:0]  doe, be;
   logic [AW-2:0] waddr;
   logic attr_sel, rd;

   pccard_lane_steer #(.ADDR_W(AW), .LANE_W(8), .ATTR_ODD_MASK(1'b1)) uut (
      .host_addr (addr),  .host_ce1_n (ce1_n), .host_ce2_n (ce2_n),
      .host_oe_n (oe_n),  .host_we_n (we_n),   .host_reg_n (reg_n),
      .host_din  (din),   .host_dout (dout),   .host_doe (doe),
      .arr_addr  (waddr), .arr_attr (attr_sel), .arr_rd (rd),
      .arr_wr_be (be),    .arr_wdata (wdata),  .arr_rdata (rdata)
   );

   logic [15:0] mem_c [WN];
   logic [15:0] mem_a [WN];
   logic [7:0]  ref_c [2*WN];
   logic [7:0]  ref_a [2*WN];

   assign rdata = attr_sel ? mem_a[waddr] : mem_c[waddr];

   always @(posedge clk) begin
      if (attr_sel) begin
         if (be[0]) mem_a[waddr][7:0]  <= wdata[7:0];
         if (be[1]) mem_a[waddr][15:8] <= wdata[15:8];
      end else begin
         if (be[0]) mem_c[waddr][7:0]  <= wdata[7:0];
         if (be[1]) mem_c[waddr][15:8] <= wdata[15:8];
      end
   end

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] get_ref(input bit at, input int idx);
      return at ? ref_a[idx] : ref_c[idx];
   endfunction

   task automatic put_ref(input bit at, input int idx, input logic [7:0] b);
      if (at) ref_a[idx] = b; else ref_c[idx] = b;
   endtask

   task automatic drive(input logic c1, c2, o, w, r, input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk);
      ce1_n = c1; ce2_n = c2; oe_n = o; we_n = w; reg_n = r; addr = a; din = d;
      #2;
   endtask

   task automatic go_idle();
      drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, addr, din);
   endtask

   // byte-wide write through the low lane; high lane carries a decoy
   task automatic wr_byte(input bit at, input logic [AW-1:0] a, input logic [7:0] b, input string req);
      bit blocked;
      blocked = at && a[0];
      drive(1'b0, 1'b1, 1'b1, 1'b0, ~at, a, {~b, b});
      chk({req, " byte write mask"}, be, blocked ? 2'b00 : (a[0] ? 2'b10 : 2'b01));
      chk("R11 byte write duplicated", wdata, {b, b});
      @(posedge clk);
      if (!blocked) put_ref(at, a, b);
      go_idle();
   endtask

   task automatic rd_byte(input bit at, input logic [AW-1:0] a, input string req);
      drive(1'b0, 1'b1, 1'b0, 1'b1, ~at, a, 16'h0);
      if (at && a[0]) chk("R8 attribute odd byte read", doe, 2'b00);
      else begin
         chk({req, " byte read lanes"}, doe, 2'b01);
         chk({req, " byte read data"}, dout[7:0], get_ref(at, a));
      end
      go_idle();
   endtask

   task automatic wr_word(input bit at, input logic [AW-2:0] wa, input bit a0, input logic [15:0] w, input string req);
      drive(1'b0, 1'b0, 1'b1, 1'b0, ~at, {wa, a0}, w);
      chk({req, " word write mask"}, be, at ? 2'b01 : 2'b11);
      chk("R10 word address", waddr, wa);
      @(posedge clk);
      put_ref(at, {wa, 1'b0}, w[7:0]);
      if (!at) put_ref(at, {wa, 1'b1}, w[15:8]);
      go_idle();
   endtask

   task automatic rd_word(input bit at, input logic [AW-2:0] wa, input bit a0, input string req);
      drive(1'b0, 1'b0, 1'b0, 1'b1, ~at, {wa, a0}, 16'h0);
      chk({req, " word read lanes"}, doe, at ? 2'b01 : 2'b11);
      chk({req, " word read even"}, dout[7:0], get_ref(at, {wa, 1'b0}));
      if (!at) chk({req, " word read odd"}, dout[15:8], get_ref(at, {wa, 1'b1}));
      go_idle();
   endtask

   task automatic wr_odd(input bit at, input logic [AW-2:0] wa, input logic [7:0] b, input string req);
      drive(1'b1, 1'b0, 1'b1, 1'b0, ~at, {wa, 1'b0}, {b, ~b});
      chk({req, " odd-only write mask"}, be, at ? 2'b00 : 2'b10);
      if (!at) chk("R5 odd-only write data", wdata[15:8], b);
      @(posedge clk);
      if (!at) put_ref(at, {wa, 1'b1}, b);
      go_idle();
   endtask

   task automatic rd_odd(input bit at, input logic [AW-2:0] wa, input bit a0, input string req);
      drive(1'b1, 1'b0, 1'b0, 1'b1, ~at, {wa, a0}, 16'h0);
      chk({req, " odd-only read lanes"}, doe, at ? 2'b00 : 2'b10);
      if (!at) chk({req, " odd-only read data"}, dout[15:8], get_ref(at, {wa, 1'b1}));
      go_idle();
   endtask

   task automatic t_standby();
      drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 16'h0);
      chk("R1 reset standby lanes", doe, 2'b00);
      chk("R1 reset standby mask", be, 2'b00);
      drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h13, 16'hFFFF);
      chk("R1 standby strobes low lanes", doe, 2'b00);
      chk("R1 standby strobes low mask", be, 2'b00);
      go_idle();
   endtask

   task automatic t_byte();
      wr_byte(1'b0, 8'h10, 8'hA5, "R2");
      wr_byte(1'b0, 8'h11, 8'h3C, "R3");
      rd_byte(1'b0, 8'h10, "R2");
      rd_byte(1'b0, 8'h11, "R3");
      rd_word(1'b0, 7'h08, 1'b0, "R4");
   endtask

   task automatic t_word();
      wr_word(1'b0, 7'h20, 1'b1, 16'h1234, "R4");
      rd_word(1'b0, 7'h20, 1'b0, "R10");
      rd_word(1'b0, 7'h20, 1'b1, "R10");
      rd_byte(1'b0, 8'h40, "R2");
      rd_byte(1'b0, 8'h41, "R3");
   endtask

   task automatic t_odd_only();
      wr_odd(1'b0, 7'h21, 8'h77, "R5");
      rd_odd(1'b0, 7'h21, 1'b0, "R5");
      rd_odd(1'b0, 7'h21, 1'b1, "R10");
      rd_word(1'b0, 7'h21, 1'b0, "R5");
   endtask

   task automatic t_qualify();
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h40, 16'h5A5A);
      chk("R6 both strobes high lanes", doe, 2'b00);
      chk("R6 both strobes high mask", be, 2'b00);
      chk("R6 both strobes high read", rd, 1'b0);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h40, 16'h0);
      chk("R6 read qualified", rd, 1'b1);
      go_idle();
   endtask

   task automatic t_contention();
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h60, 16'hCAFE);
      chk("R7 both strobes low lanes", doe, 2'b00);
      chk("R7 both strobes low mask", be, 2'b11);
      @(posedge clk);
      put_ref(1'b0, 8'h60, 8'hFE);
      put_ref(1'b0, 8'h61, 8'hCA);
      go_idle();
      rd_word(1'b0, 7'h30, 1'b0, "R7");
   endtask

   task automatic t_attr();
      wr_word(1'b1, 7'h05, 1'b0, 16'hBEEF, "R9");
      rd_word(1'b1, 7'h05, 1'b0, "R8");
      wr_byte(1'b1, 8'h0B, 8'h11, "R9");
      wr_odd(1'b1, 7'h05, 8'h22, "R9");
      rd_byte(1'b1, 8'h0B, "R8");
      rd_odd(1'b1, 7'h05, 1'b0, "R8");
      rd_byte(1'b1, 8'h0A, "R9");
      rd_word(1'b0, 7'h05, 1'b0, "R9 common plane untouched");
   endtask

   initial begin
      for (int i = 0; i < WN; i++) begin
         mem_c[i] = '0;
         mem_a[i] = '0;
      end
      for (int i = 0; i < 2*WN; i++) begin
         ref_c[i] = '0;
         ref_a[i] = '0;
      end
      repeat (3) @(posedge clk);
      t_standby();
      t_byte();
      t_word();
      t_odd_only();
      t_qualify();
      t_contention();
      t_attr();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=0", 1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule